// File: doc/BRIEF.md
# Hierarchical interrupt status encoder

This block gathers interrupt requests from three source groups of decreasing rank (critical, main and peripheral), applies the mask state it holds for the main and peripheral groups, and folds a separate 32-bit DMA pending bank into the peripheral group as source 0. From the result it builds one status word. Each of the three tiers reports its own winner in a fixed field with its own flag. Software reads the critical tier first, then the main tier, then the peripheral tier, and services the first tier whose flag is set.

Two codes in the upper tiers point downward. Critical code 2 stands for a peripheral source from a build-time set of high-rank peripherals. Main code 4 stands for any other peripheral. In both cases the peripheral field names the source. When the peripheral field reads 0, the DMA bank is the source, and the block also gives the lowest active DMA bit number on its own output. Request inputs are registered once. The status word is then formed combinationally from the registered request, mask and pending state. Per-source priority levels are fixed at zero, so within a group the lowest source number wins.

Top module: `irq_status_enc`

## Requirements
- R1: After reset, every main, peripheral and DMA mask bit is 1 and every DMA pending bit is 0. With no critical request, status reads 0 and dma_valid is 0, whatever the main and peripheral request inputs hold.
- R2: Status bit 10 is set when any critical candidate is active, and bits [9:8] hold the number of the lowest active candidate. Candidates 0, 1 and 3 are crit_req bits 0, 1 and 3, and no mask applies to them.
- R3: Critical candidate 2 is active when any unmasked, active peripheral source belongs to the high-rank set HI_PERI. The input crit_req[2] is ignored.
- R4: Status bit 21 is set when any main candidate is active, and bits [20:16] hold the lowest active number. Main source k is disabled by main mask bit 16-k (1 = masked). Writes with wr_sel = 0 load the main mask from wr_data[16:0].
- R5: Main candidate 4 is active when any unmasked, active peripheral source lies outside HI_PERI. The input main_req[4] is ignored.
- R6: Status bit 29 is set when any unmasked peripheral source is active. Peripheral source k is disabled by peripheral mask bit 31-k, and writes with wr_sel = 1 load this mask. Bits [28:24] hold the lowest active source in HI_PERI if there is one, and otherwise the lowest active source overall.
- R7: Peripheral source 0 is active when DMA pending AND NOT DMA mask is nonzero. The input peri_req[0] is ignored.
- R8: dma_valid is set when DMA pending AND NOT DMA mask is nonzero, and dma_idx holds the lowest set bit of that vector.
- R9: A bit of dma_evt sets the matching DMA pending bit. A write with wr_sel = 3 clears each pending bit whose wr_data bit is 1, and wr_data bits that are 0 leave their pending bits unchanged. If a bit is set and cleared in the same cycle, it stays set.
- R10: Writes with wr_sel = 2 load the DMA mask. A 1 in the DMA mask removes that bit from both dma_valid and the DMA cascade.
- R11: A change of request or register state appears on status at the first clock edge that samples it, and not before. Each tier's flag and field are produced independently of the other tiers, and the field of a tier whose flag is clear reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| crit_req | input | 4 | Critical request levels (bit 2 unused) |
| main_req | input | MAIN_N | Main request levels (bit 4 unused) |
| peri_req | input | PERI_N | Peripheral request levels (bit 0 unused) |
| dma_evt | input | DMA_N | Per-bit DMA pending set pulses |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 main mask, 1 peripheral mask, 2 DMA mask, 3 DMA pending clear |
| wr_data | input | 32 | Write data |
| status | output | 32 | Encoded three-tier status word |
| dma_valid | output | 1 | An unmasked DMA pending bit exists |
| dma_idx | output | 5 | Lowest unmasked DMA pending bit number |

## Verification
The bench drives peripheral requests that sit both inside and outside the high-rank set at the same moment. A design that chose the peripheral field by plain lowest number would then name a low-rank source under critical code 2. It also raises the placeholder inputs crit_req[2], main_req[4] and peri_req[0] on their own, because a design that let them through would report phantom codes. The bench drives a DMA set and clear on the same bit in one cycle, where a design that gave the clear priority would lose an event. It also checks the reversed mask bit mapping for source 0 of the peripheral group: a design that did not reverse it would let the DMA cascade through while the peripheral mask is meant to block it.

// File: rtl/irq_enc_pkg.sv
package irq_enc_pkg;

  // status word field positions (software decodes these)
  localparam int CRIT_FLAG = 10;
  localparam int CRIT_LSB  = 8;
  localparam int MAIN_FLAG = 21;
  localparam int MAIN_LSB  = 16;
  localparam int PERI_FLAG = 29;
  localparam int PERI_LSB  = 24;
  localparam int CODE_W    = 5;
  localparam int CRIT_W    = 2;
  localparam int CRIT_N    = 4;

  // placeholder codes
  localparam int CRIT_REDIR   = 2;
  localparam int MAIN_REDIR   = 4;
  localparam int PERI_CASCADE = 0;

  typedef enum logic [1:0] {
    WS_MAIN_MASK = 2'd0,
    WS_PERI_MASK = 2'd1,
    WS_DMA_MASK  = 2'd2,
    WS_DMA_CLR   = 2'd3
  } wsel_e;

  typedef struct packed {
    logic             valid;
    logic [CODE_W-1:0] idx;
  } pick_t;

  // lowest set bit of a 32-bit vector, 0 when empty
  function automatic logic [CODE_W-1:0] first_set(input logic [31:0] v);
    logic [CODE_W-1:0] r;
    r = '0;
    for (int i = 31; i >= 0; i--) begin
      if (v[i]) r = CODE_W'(i);
    end
    return r;
  endfunction

  // assemble the three independent tiers into one word
  function automatic logic [31:0] pack_status(input pick_t c, input pick_t m,
                                              input pick_t p);
    logic [31:0] s;
    s = '0;
    s[CRIT_FLAG] = c.valid;
    s[MAIN_FLAG] = m.valid;
    s[PERI_FLAG] = p.valid;
    if (c.valid) s[CRIT_LSB +: CRIT_W] = c.idx[CRIT_W-1:0];
    if (m.valid) s[MAIN_LSB +: CODE_W] = m.idx;
    if (p.valid) s[PERI_LSB +: CODE_W] = p.idx;
    return s;
  endfunction

endpackage

// File: rtl/irq_pick.sv
module irq_pick
  import irq_enc_pkg::*;
#(
  parameter int N = 32
) (
  input  logic [N-1:0] act,
  output pick_t        win
);

  logic [31:0] wide;

  assign wide      = 32'(act);
  assign win.valid = |act;
  assign win.idx   = first_set(wide);

  always_comb begin
    if (win.valid) begin
      // R8
      pick_hit_chk: assert (wide[win.idx]);
      // R8
      pick_lowest_chk: assert ((wide & ((32'd1 << win.idx) - 32'd1)) == 32'd0);
    end
  end

endmodule

// File: rtl/irq_dma_bank.sv
module irq_dma_bank
  import irq_enc_pkg::*;
#(
  parameter int N = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] evt,
  input  logic         mask_we,
  input  logic         clr_we,
  input  logic [N-1:0] wdata,
  output pick_t        win
);

  logic [N-1:0] pend_q;
  logic [N-1:0] mask_q;
  logic [N-1:0] clr_vec;
  logic [N-1:0] act;

  assign clr_vec = clr_we ? wdata : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      mask_q <= '1;
    end else begin
      pend_q <= (pend_q & ~clr_vec) | evt;
      if (mask_we) mask_q <= wdata;
    end
  end

  assign act = pend_q & ~mask_q;

  irq_pick #(.N(N)) u_pick (
    .act (act),
    .win (win)
  );

  // R9
  dma_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> ((pend_q & $past(evt)) == $past(evt)));

  // R9
  dma_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> ((pend_q & $past(clr_vec & ~evt)) == '0));

endmodule

// File: rtl/irq_status_enc.sv
module irq_status_enc
  import irq_enc_pkg::*;
#(
  parameter int          MAIN_N  = 17,
  parameter int          PERI_N  = 32,
  parameter int          DMA_N   = 32,
  parameter logic [31:0] HI_PERI = 32'h0000_0102
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CRIT_N-1:0] crit_req,
  input  logic [MAIN_N-1:0] main_req,
  input  logic [PERI_N-1:0] peri_req,
  input  logic [DMA_N-1:0]  dma_evt,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [31:0]       wr_data,
  output logic [31:0]       status,
  output logic              dma_valid,
  output logic [CODE_W-1:0] dma_idx
);

  localparam logic [PERI_N-1:0] HI_SET = HI_PERI[PERI_N-1:0];

  // registered request and mask state
  logic [CRIT_N-1:0] crit_q;
  logic [MAIN_N-1:0] main_q;
  logic [PERI_N-1:0] peri_q;
  logic [MAIN_N-1:0] main_mask_q;
  logic [PERI_N-1:0] peri_mask_q;

  // write decode, brought out for the checks
  logic we_main_mask;
  logic we_peri_mask;
  logic we_dma_mask;
  logic we_dma_clr;

  assign we_main_mask = wr_en && (wsel_e'(wr_sel) == WS_MAIN_MASK);
  assign we_peri_mask = wr_en && (wsel_e'(wr_sel) == WS_PERI_MASK);
  assign we_dma_mask  = wr_en && (wsel_e'(wr_sel) == WS_DMA_MASK);
  assign we_dma_clr   = wr_en && (wsel_e'(wr_sel) == WS_DMA_CLR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crit_q      <= '0;
      main_q      <= '0;
      peri_q      <= '0;
      main_mask_q <= '1;
      peri_mask_q <= '1;
    end else begin
      crit_q <= crit_req;
      main_q <= main_req;
      peri_q <= peri_req;
      if (we_main_mask) main_mask_q <= wr_data[MAIN_N-1:0];
      if (we_peri_mask) peri_mask_q <= wr_data[PERI_N-1:0];
    end
  end

  // placeholder inputs carry no meaning
  logic sink_unused;
  assign sink_unused = crit_q[CRIT_REDIR] ^ main_q[MAIN_REDIR] ^ peri_q[PERI_CASCADE];

  // DMA pending bank
  pick_t dma_win;

  irq_dma_bank #(.N(DMA_N)) u_dma (
    .clk     (clk),
    .rst_n   (rst_n),
    .evt     (dma_evt),
    .mask_we (we_dma_mask),
    .clr_we  (we_dma_clr),
    .wdata   (wr_data[DMA_N-1:0]),
    .win     (dma_win)
  );

  assign dma_valid = dma_win.valid;
  assign dma_idx   = dma_win.idx;

  // peripheral group: reversed mask mapping, source 0 is the cascade
  logic [PERI_N-1:0] peri_act;
  logic [PERI_N-1:0] hi_act;
  logic [PERI_N-1:0] lo_act;
  logic              lo_any;

  for (genvar k = 0; k < PERI_N; k++) begin : g_peri
    if (k == PERI_CASCADE) begin : g_casc
      assign peri_act[k] = dma_win.valid & ~peri_mask_q[PERI_N-1-k];
    end else begin : g_src
      assign peri_act[k] = peri_q[k] & ~peri_mask_q[PERI_N-1-k];
    end
  end

  assign hi_act = peri_act & HI_SET;
  assign lo_act = peri_act & ~HI_SET;
  assign lo_any = |lo_act;

  pick_t hi_win;
  pick_t all_win;
  pick_t peri_win;

  irq_pick #(.N(PERI_N)) u_pick_hi (
    .act (hi_act),
    .win (hi_win)
  );

  irq_pick #(.N(PERI_N)) u_pick_all (
    .act (peri_act),
    .win (all_win)
  );

  assign peri_win.valid = all_win.valid;
  assign peri_win.idx   = hi_win.valid ? hi_win.idx : all_win.idx;

  // critical group: no mask, slot 2 stands for high-rank peripherals
  logic [CRIT_N-1:0] crit_act;
  pick_t             crit_win;

  for (genvar k = 0; k < CRIT_N; k++) begin : g_crit
    if (k == CRIT_REDIR) begin : g_redir
      assign crit_act[k] = hi_win.valid;
    end else begin : g_src
      assign crit_act[k] = crit_q[k];
    end
  end

  irq_pick #(.N(CRIT_N)) u_pick_crit (
    .act (crit_act),
    .win (crit_win)
  );

  // main group: reversed mask mapping, slot 4 stands for other peripherals
  logic [MAIN_N-1:0] main_act;
  pick_t             main_win;

  for (genvar k = 0; k < MAIN_N; k++) begin : g_main
    if (k == MAIN_REDIR) begin : g_redir
      assign main_act[k] = lo_any;
    end else begin : g_src
      assign main_act[k] = main_q[k] & ~main_mask_q[MAIN_N-1-k];
    end
  end

  irq_pick #(.N(MAIN_N)) u_pick_main (
    .act (main_act),
    .win (main_win)
  );

  assign status = pack_status(crit_win, main_win, peri_win);

  // decoded fields for the checks
  logic [CRIT_W-1:0] crit_field;
  logic [CODE_W-1:0] main_field;
  logic [CODE_W-1:0] peri_field;

  assign crit_field = status[CRIT_LSB +: CRIT_W];
  assign main_field = status[MAIN_LSB +: CODE_W];
  assign peri_field = status[PERI_LSB +: CODE_W];

  // R3
  crit_redir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status[CRIT_FLAG] && crit_field == CRIT_W'(CRIT_REDIR))
      |-> (status[PERI_FLAG] && HI_PERI[peri_field]));

  // R5
  main_redir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status[MAIN_FLAG] && main_field == CODE_W'(MAIN_REDIR))
      |-> (status[PERI_FLAG] && !status[CRIT_FLAG] ? !HI_PERI[peri_field] : status[PERI_FLAG]));

  // R4
  main_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status[MAIN_FLAG] && main_field != CODE_W'(MAIN_REDIR))
      |-> (main_q[main_field] && !main_mask_q[MAIN_N-1-int'(main_field)]));

  // R6
  peri_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status[PERI_FLAG] && peri_field != CODE_W'(PERI_CASCADE))
      |-> (peri_q[peri_field] && !peri_mask_q[PERI_N-1-int'(peri_field)]));

  // R7
  cascade_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status[PERI_FLAG] && peri_field == CODE_W'(PERI_CASCADE))
      |-> (dma_valid && !peri_mask_q[PERI_N-1]));

endmodule

// File: tb/irq_status_enc_test.sv
module irq_status_enc_test;

  localparam logic [31:0] HI = 32'h0000_0102;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  crit_req = '0;
  logic [16:0] main_req = '0;
  logic [31:0] peri_req = '0;
  logic [31:0] dma_evt = '0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] status;
  logic        dma_valid;
  logic [4:0]  dma_idx;

  always #10 clk = ~clk;

  irq_status_enc uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .crit_req  (crit_req),
    .main_req  (main_req),
    .peri_req  (peri_req),
    .dma_evt   (dma_evt),
    .wr_en     (wr_en),
    .wr_sel    (wr_sel),
    .wr_data   (wr_data),
    .status    (status),
    .dma_valid (dma_valid),
    .dma_idx   (dma_idx)
  );

  int checks = 0;
  int errors = 0;
  bit cmp_on = 1'b0;
  bit done = 1'b0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // behavioural reference state
  logic [3:0]  m_crit;
  logic [16:0] m_main;
  logic [31:0] m_peri;
  logic [16:0] m_mmask;
  logic [31:0] m_pmask;
  logic [31:0] m_dmask;
  logic [31:0] m_dpend;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_crit  <= '0;
      m_main  <= '0;
      m_peri  <= '0;
      m_mmask <= '1;
      m_pmask <= '1;
      m_dmask <= '1;
      m_dpend <= '0;
    end else begin
      logic [31:0] nd;
      m_crit <= crit_req;
      m_main <= main_req;
      m_peri <= peri_req;
      nd = m_dpend;
      if (wr_en) begin
        case (wr_sel)
          2'd0: m_mmask <= wr_data[16:0];
          2'd1: m_pmask <= wr_data;
          2'd2: m_dmask <= wr_data;
          default: nd = nd & ~wr_data;
        endcase
      end
      m_dpend <= nd | dma_evt;
    end
  end

  function automatic int lowest(input logic [31:0] v);
    for (int i = 0; i < 32; i++) if (v[i]) return i;
    return -1;
  endfunction

  function automatic logic [31:0] ref_status();
    logic [31:0] dact, pa, hi, lo, s;
    int cw, mw, pw;
    bit cand;
    dact = m_dpend & ~m_dmask;
    for (int k = 0; k < 32; k++)
      pa[k] = ((k == 0) ? (dact != 0) : m_peri[k]) && !m_pmask[31-k];
    hi = pa & HI;
    lo = pa & ~HI;
    s = '0;
    cw = -1;
    for (int k = 0; k < 4; k++) begin
      cand = (k == 2) ? (hi != 0) : m_crit[k];
      if (cand && cw < 0) cw = k;
    end
    if (cw >= 0) s = s | 32'h400 | 32'(cw << 8);
    mw = -1;
    for (int k = 0; k < 17; k++) begin
      cand = (k == 4) ? (lo != 0) : (m_main[k] && !m_mmask[16-k]);
      if (cand && mw < 0) mw = k;
    end
    if (mw >= 0) s = s | 32'h0020_0000 | 32'(mw << 16);
    pw = (hi != 0) ? lowest(hi) : lowest(pa);
    if (pw >= 0) s = s | 32'h2000_0000 | 32'(pw << 24);
    return s;
  endfunction

  function automatic logic [31:0] ref_dma();
    int d;
    d = lowest(m_dpend & ~m_dmask);
    return (d < 0) ? 32'd0 : (32'h20 | 32'(d));
  endfunction

  // cycle-by-cycle comparison against the reference
  always @(negedge clk) begin
    if (cmp_on) begin
      logic [31:0] e;
      e = ref_status();
      chk("R2 critical tier", {21'd0, status[10:8]}, {21'd0, e[10:8]});
      chk("R4 main tier", {26'd0, status[21:16]}, {26'd0, e[21:16]});
      chk("R6 peripheral tier", {26'd0, status[29:24]}, {26'd0, e[29:24]});
      chk("R11 whole status", status, e);
      chk("R8 dma index", {26'd0, dma_valid, dma_idx}, ref_dma());
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] sel, input logic [31:0] d);
    wr_en = 1'b1;
    wr_sel = sel;
    wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    wr_data = '0;
  endtask

  initial begin
    step(3);
    rst_n = 1'b1;
    cmp_on = 1'b1;
    step(1);
    chk("R1 status after reset", status, 32'd0);
    chk("R1 dma_valid after reset", {31'd0, dma_valid}, 32'd0);
    // masks all 1 after reset block main and peripheral requests
    main_req = '1;
    peri_req = '1;
    step(2);
    chk("R1 reset masks block requests", status, 32'd0);
    main_req = '0;
    peri_req = '0;
    // placeholder critical input
    crit_req = 4'b0100;
    step(1);
    chk("R3 crit_req[2] ignored", status, 32'd0);
    crit_req = '0;
    wr(2'd1, 32'd0);
    wr(2'd0, 32'd0);
    peri_req = 32'h1;
    step(1);
    chk("R7 peri_req[0] ignored", status, 32'd0);
    chk("R7 no dma", {31'd0, dma_valid}, 32'd0);
    peri_req = 32'h20;
    step(1);
    chk("R5 low-rank peripheral via main code 4", status, 32'h2524_0000);
    peri_req = 32'h100;
    step(1);
    chk("R3 high-rank peripheral via critical code 2", status, 32'h2800_0600);
    peri_req = 32'h120;
    step(1);
    chk("R6 high-rank wins peripheral field", status, 32'h2824_0600);
    peri_req = '0;
    main_req = 17'h10;
    step(1);
    chk("R5 main_req[4] ignored", status, 32'd0);
    wr(2'd0, 32'h0000_2000);
    main_req = 17'h8;
    step(1);
    chk("R4 mask bit 13 masks main source 3", status, 32'd0);
    main_req = 17'h48;
    step(1);
    chk("R4 next main source wins", status, 32'h0026_0000);
    main_req = '0;
    crit_req = 4'b1011;
    peri_req = 32'h100;
    step(1);
    chk("R2 critical source 0 outranks code 2", status, 32'h2800_0400);
    crit_req = 4'b1010;
    step(1);
    chk("R2 critical source 1", status, 32'h2800_0500);
    crit_req = '0;
    peri_req = '0;
    dma_evt = 32'h80;
    step(1);
    dma_evt = '0;
    chk("R10 dma mask hides pending bit", {26'd0, dma_valid, dma_idx}, 32'd0);
    chk("R10 dma mask blocks cascade", status, 32'd0);
    wr(2'd2, 32'd0);
    chk("R8 dma index 7", {26'd0, dma_valid, dma_idx}, 32'h27);
    chk("R7 cascade as peripheral 0", status, 32'h2024_0000);
    dma_evt = 32'h8;
    step(1);
    dma_evt = '0;
    chk("R8 lower dma bit wins", {26'd0, dma_valid, dma_idx}, 32'h23);
    wr(2'd3, 32'd0);
    chk("R9 zero write clears nothing", {26'd0, dma_valid, dma_idx}, 32'h23);
    wr(2'd3, 32'h8);
    chk("R9 write one clears bit 3", {26'd0, dma_valid, dma_idx}, 32'h27);
    dma_evt = 32'h80;
    wr(2'd3, 32'h80);
    dma_evt = '0;
    chk("R9 set wins over clear", {26'd0, dma_valid, dma_idx}, 32'h27);
    wr(2'd3, 32'h80);
    chk("R9 bit 7 cleared", {26'd0, dma_valid, dma_idx}, 32'd0);
    chk("R9 cascade gone", status, 32'd0);
    dma_evt = 32'h4;
    step(1);
    dma_evt = '0;
    wr(2'd1, 32'h8000_0000);
    chk("R6 mask bit 31 blocks peripheral 0", status, 32'd0);
    chk("R8 dma still pending", {26'd0, dma_valid, dma_idx}, 32'h22);
    wr(2'd3, 32'hFFFF_FFFF);
    wr(2'd1, 32'd0);
    peri_req = 32'h20;
    #1;
    chk("R11 no change before edge", status, 32'd0);
    step(1);
    chk("R11 change after one edge", status, 32'h2524_0000);
    peri_req = '0;
    // mixed traffic compared against the reference every cycle
    for (int i = 0; i < 4000; i++) begin
      crit_req = ($urandom_range(0, 7) == 0) ? 4'($urandom) : 4'd0;
      main_req = 17'($urandom & $urandom & $urandom);
      peri_req = $urandom & $urandom & $urandom & $urandom;
      dma_evt  = ($urandom_range(0, 3) == 0) ? (32'd1 << $urandom_range(0, 31)) : 32'd0;
      wr_en    = ($urandom_range(0, 5) == 0);
      wr_sel   = 2'($urandom);
      wr_data  = $urandom & $urandom;
      step(1);
    end
    wr_en = 1'b0;
    step(2);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule